// File: doc/BRIEF.md
# Charger Command Register Bank with Supervisory Timeout

This block holds the host-visible control words of a battery charger. These are a 16-bit option word, a 16-bit charge-current word and a 16-bit charge-voltage word. The host reaches them through a byte-wide write/read port. A supervisory timer counts a slow tick-enable input. If the host does not refresh the charge commands within the selected window, the timer zeroes the charge-current word. This suspends charging, and the block raises a readable expired flag.

The block also watches a battery-presence pin. When the auto-disable option is set and the pin falls, the block clears the input-current-limit enable bit once. The host may set that bit again afterwards. A low-power option bit holds the monitor-enable output low. Serial bus decoding and power-stage control sit outside this block.

Top module: `charge_reg_guard`

## Requirements
- R1: After reset, address 0x00 reads 0x0E and 0x01 reads 0xE2. Addresses 0x02 to 0x06 read 0x00, `expired` is 0, `chg_suspend` is 1 and `mon_en` is 0.
- R2: Bytes written to 0x00..0x05 read back unchanged, with the low byte of each word at the even address. Option word = 0x01:0x00, current = 0x03:0x02, voltage = 0x05:0x04. Address 0x06 reads {7'b0, expired}. Addresses 0x07..0x0F read 0x00 and ignore writes.
- R3: Option bits 14:13 (bits 6:5 of address 0x01) pick the timeout. 00 turns the timer off, 01 gives T_SHORT ticks, 10 gives T_MID ticks and 11 gives T_LONG ticks.
- R4: After a re-arm, the N-th tick (N = selected count) sets `expired` and clears the current word to zero. Tick N-1 leaves both untouched.
- R5: A write to 0x01, 0x02, 0x03, 0x04 or 0x05 restarts the count and clears `expired`. A write to 0x00 does neither.
- R6: A re-arming write that lands in the same cycle as the terminal tick wins. No expiry occurs, and the written byte is stored.
- R7: With option bit 12 set, a falling edge of `bat_present`, seen through a two-flop synchronizer, clears option bit 1 once. A later host write may set bit 1 again while the pin stays low.
- R8: With option bit 12 clear, a falling `bat_present` leaves option bit 1 unchanged.
- R9: `mon_en` is the inverse of option bit 15.
- R10: `chg_suspend` is 1 exactly when the charge-current word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 4 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| tick | input | 1 | One-cycle timebase pulse (nominally 1 Hz) |
| bat_present | input | 1 | Asynchronous battery-presence pin, low when absent |
| expired | output | 1 | Timeout has fired since the last re-arm |
| chg_suspend | output | 1 | Charge-current word is zero |
| mon_en | output | 1 | Monitor enable, held low in low-power mode |

## Verification
The bench builds the block with T_SHORT=3, T_MID=5 and T_LONG=7. With these values every timeout select can be driven to expiry within a few cycles. For each select the bench sweeps every tick count below the terminal one, then checks the exact tick that expires. The small counts also leave room to probe the same-cycle collision between a re-arming write and the terminal tick, and to check both settings of the presence-pin auto-disable option.

// File: rtl/charge_reg_guard.sv
module charge_reg_guard #(
  parameter int T_SHORT = 5,
  parameter int T_MID   = 88,
  parameter int T_LONG  = 175,
  localparam int CW = $clog2(T_LONG + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick,
  input  logic       bat_present,
  output logic       expired,
  output logic       chg_suspend,
  output logic       mon_en
);

  logic [15:0] opt, ichg, vchg;
  logic [CW-1:0] cnt, limit;
  logic bp_s1, bp_s2, bp_d;

  wire [1:0] sel   = opt[14:13];
  wire wd_on       = sel != 2'b00;
  wire rearm       = wr_en && addr >= 4'd1 && addr <= 4'd5;
  wire bp_fall     = bp_d && !bp_s2;
  wire expire_now  = wd_on && !expired && tick && !rearm && (cnt == limit - CW'(1));
  wire auto_clear  = opt[12] && bp_fall && !(wr_en && addr == 4'd0);

  always_comb begin
    case (sel)
      2'b01:   limit = CW'(T_SHORT);
      2'b10:   limit = CW'(T_MID);
      default: limit = CW'(T_LONG);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt     <= 16'hE20E;
      ichg    <= '0;
      vchg    <= '0;
      cnt     <= '0;
      expired <= 1'b0;
      bp_s1   <= 1'b1;
      bp_s2   <= 1'b1;
      bp_d    <= 1'b1;
    end else begin
      bp_s1 <= bat_present;
      bp_s2 <= bp_s1;
      bp_d  <= bp_s2;

      if (rearm) begin
        cnt     <= '0;
        expired <= 1'b0;
      end else if (expire_now) begin
        cnt     <= '0;
        expired <= 1'b1;
      end else if (wd_on && !expired && tick) begin
        cnt <= cnt + CW'(1);
      end

      if (expire_now) ichg <= '0;

      if (auto_clear) opt[1] <= 1'b0;

      if (wr_en) begin
        case (addr)
          4'd0: opt[7:0]   <= wdata;
          4'd1: opt[15:8]  <= wdata;
          4'd2: ichg[7:0]  <= wdata;
          4'd3: ichg[15:8] <= wdata;
          4'd4: vchg[7:0]  <= wdata;
          4'd5: vchg[15:8] <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = opt[7:0];
      4'd1:    rdata = opt[15:8];
      4'd2:    rdata = ichg[7:0];
      4'd3:    rdata = ichg[15:8];
      4'd4:    rdata = vchg[7:0];
      4'd5:    rdata = vchg[15:8];
      4'd6:    rdata = {7'b0, expired};
      default: rdata = 8'h00;
    endcase
  end

  assign chg_suspend = ichg == 16'h0;
  assign mon_en      = !opt[15];

  // R4
  expire_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> chg_suspend);

  // R3
  off_never_expires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(wd_on));

  // R5
  rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !expired);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < limit);

  // R8
  bit1_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(opt[1]) && !$past(wr_en && addr == 4'd0)) |-> $past(opt[12]));

endmodule

// File: tb/tb_charge_reg_guard.sv
module tb_charge_reg_guard;
  localparam int CLK_P = 10;
  localparam int TS = 3, TM = 5, TL = 7;

  logic clk = 0, rst_n = 0, wr_en = 0, tick = 0, bat_present = 1;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic expired, chg_suspend, mon_en;
  int errs = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  charge_reg_guard #(.T_SHORT(TS), .T_MID(TM), .T_LONG(TL)) dut (
    .clk, .rst_n, .wr_en, .addr, .wdata, .rdata, .tick, .bat_present,
    .expired, .chg_suspend, .mon_en);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++; checks++;
    $display("FAIL watchdog timeout");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    rd(0, d); chk("R1 opt lo", d, 8'h0E);
    rd(1, d); chk("R1 opt hi", d, 8'hE2);
    for (int a = 2; a <= 6; a++) begin rd(4'(a), d); chk("R1 zero", d, 0); end
    chk("R1 expired", expired, 0);
    chk("R1 suspend", chg_suspend, 1);
    chk("R1 mon_en", mon_en, 0);

    // R2 readback and invalid addresses
    for (int a = 2; a <= 5; a++) wr(4'(a), 8'(8'h31 * a));
    for (int a = 2; a <= 5; a++) begin rd(4'(a), d); chk("R2 readback", d, 8'(8'h31 * a)); end
    for (int a = 7; a <= 15; a++) begin wr(4'(a), 8'hFF); rd(4'(a), d); chk("R2 invalid", d, 0); end
    chk("R10 suspend low", chg_suspend, 0);

    // R3 R4 sweep each select
    for (int s = 1; s <= 3; s++) begin
      automatic int n = (s == 1) ? TS : (s == 2) ? TM : TL;
      wr(2, 8'h40);
      wr(1, 8'(8'h10 | (s << 5)));
      for (int k = 1; k < n; k++) begin
        tk(); chk("R4 before terminal", expired, 0);
      end
      rd(2, d); chk("R4 current kept", d, 8'h40);
      tk();
      chk("R3 R4 expired at N", expired, 1);
      rd(2, d); chk("R4 current lo zero", d, 0);
      rd(3, d); chk("R4 current hi zero", d, 0);
      chk("R10 suspend", chg_suspend, 1);
      rd(6, d); chk("R2 status reg", d, 1);
      // R5 addr0 does not re-arm
      wr(0, 8'h0E); chk("R5 addr0 no rearm", expired, 1);
      wr(4, 8'h12); chk("R5 addr4 rearm", expired, 0);
    end

    // R3 select 00 disables
    wr(1, 8'h10);
    wr(2, 8'h05);
    for (int k = 0; k < 20; k++) tk();
    chk("R3 disabled", expired, 0);
    rd(2, d); chk("R3 current kept", d, 8'h05);
    chk("R9 mon_en on", mon_en, 1);
    wr(1, 8'h90); chk("R9 mon_en off", mon_en, 0);

    // R6 collision: write with terminal tick (select 01)
    wr(1, 8'hB0);
    for (int k = 1; k < TS; k++) tk();
    @(negedge clk); tick = 1; wr_en = 1; addr = 2; wdata = 8'h77;
    @(negedge clk); tick = 0; wr_en = 0;
    chk("R6 no expiry", expired, 0);
    rd(2, d); chk("R6 write kept", d, 8'h77);
    for (int k = 1; k < TS; k++) tk();
    chk("R6 recount", expired, 0);
    tk(); chk("R6 expires after full window", expired, 1);

    // R7 auto-disable with bit12 set
    wr(1, 8'h10); wr(0, 8'h0E);
    bat_present = 0; idle(6);
    rd(0, d); chk("R7 bit1 cleared", d, 8'h0C);
    wr(0, 8'h0E); idle(6);
    rd(0, d); chk("R7 once only", d, 8'h0E);
    bat_present = 1; idle(6);

    // R8 bit12 clear: no effect
    wr(1, 8'h00);
    bat_present = 0; idle(6);
    rd(0, d); chk("R8 bit1 kept", d, 8'h0E);
    bat_present = 1; idle(4);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule